// File: doc/BRIEF.md
# Round-Robin Masked Interrupt Selector

This block takes a bank of level interrupt status lines, 32 or 64 of them, and serves up to two processors. Each processor has its own enable mask. The block ANDs the raw status with that mask to form the processor's pending set. It then picks one pending source and presents it as a registered index with a valid flag. The processor consumes the offer by pulsing its take line. The search for the next offer starts at a per-processor resume pointer and wraps around, so that over time every enabled source gets its turn and none is favoured.

Software reaches the masks through a small write port and a combinational read port. The address holds a processor-select bit above a word index. The mask words appear in reverse order. Each processor also drives a summary request line that is high whenever its pending set is non-empty.

Each processor port runs a two-state machine:
- ST_SCAN searches the pending set. It stays in ST_SCAN while nothing is pending. It moves to ST_HOLD on the edge where the search finds a source, and latches the index on that edge.
- ST_HOLD offers the latched index. It stays in ST_HOLD until take is seen. On take it returns to ST_SCAN and moves the pointer to one past the granted index.

Top module: `rr_irq_selector`

## Requirements
- R1: After reset, every mask bit reads zero, no grant is valid and both summary lines are low. Both resume pointers are zero, so the first search begins at source 0.
- R2: The pending set of a processor is `src_status & mask`. Its `cpu_irq` bit is high in the same cycle exactly when that set is non-zero.
- R3: A new grant names the first pending source found when counting upward from the resume pointer, wrapping from the highest source back to source 0.
- R4: A take during a valid grant sets the resume pointer to the granted index plus one, modulo the width. The next search therefore skips every source up to and including the one just served.
- R5: A valid grant and its index stay unchanged until take is seen, even if the granted source or its mask bit drops in the meantime.
- R6: While a processor has no pending source, no grant becomes valid and its pointer does not move. A take pulse while no grant is valid has no effect.
- R7: Address bit WAW selects the processor (0 or 1). The low WAW bits select a word. Word w holds sources ((w XOR (WORDS-1))*32) to +31, and source n sits at bit n mod 32. With 64 sources, word 0 therefore covers sources 32..63 and word 1 covers sources 0..31.
- R8: The two processors have independent masks and pointers. A source may be routed to either processor, to both or to neither, and serving one processor never changes the other's offer.
- R9: A grant becomes valid on the first clock edge after pending appears while in ST_SCAN. After a take, the next grant appears one further edge later: valid is low for one cycle.
- R10: With DUAL_CPU = 0, writes to processor 1's mask are ignored. Its mask reads back zero, and its grant and summary line stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_status | input | SRC_W | Raw level status of all sources |
| wr_en | input | 1 | Mask word write strobe |
| wr_addr | input | WAW+1 | Write address {processor, word} |
| wr_data | input | 32 | Mask word write data |
| rd_addr | input | WAW+1 | Read address {processor, word} |
| rd_data | output | 32 | Mask word read data (combinational) |
| take | input | 2 | Per-processor grant consume pulse |
| grant_vld | output | 2 | Per-processor grant valid |
| grant_idx0 | output | IDX_W | Granted source for processor 0 |
| grant_idx1 | output | IDX_W | Granted source for processor 1 |
| cpu_irq | output | 2 | Per-processor summary request |

## Verification
A corrupt resume pointer does not show until the next grant is made. It then appears as a wrong `grant_idx`, one edge after the following take, and it repeats on every later search. The bench therefore follows long take sequences against a model pointer, including wraps at both ends of the range. A state machine stuck in ST_HOLD, or leaving it too early, shows as `grant_vld` failing to drop for one cycle after take, or as the index changing while the grant is held. The bench samples each cycle of those windows. An error in the word reversal or in the processor-select bit is hidden from readback alone. It shows as grants for the wrong source, which the directed mapping case exposes on the first offer.

// File: rtl/rr_irq_pkg.sv
`timescale 1ns/1ps
package rr_irq_pkg;

    localparam int WORD_BITS = 32;
    localparam int NUM_CPU   = 2;

    typedef enum logic [0:0] {
        ST_SCAN = 1'b0,
        ST_HOLD = 1'b1
    } port_state_e;

endpackage

// File: rtl/rr_mask_bank.sv
`timescale 1ns/1ps
module rr_mask_bank #(
    parameter int SRC_W  = 64,
    parameter int WORDS  = SRC_W / 32,
    parameter int WAW    = 1,
    parameter bit ENABLE = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WAW-1:0]   wr_word,
    input  logic [31:0]      wr_data,
    input  logic [WAW-1:0]   rd_word,
    output logic [31:0]      rd_data,
    output logic [SRC_W-1:0] mask
);
    import rr_irq_pkg::*;

    logic [WORD_BITS-1:0] word_q [WORDS];

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        // register word w holds the source block with the reversed number
        localparam int BLK = w ^ (WORDS - 1);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q[w] <= '0;
            end else if (ENABLE && wr_en && (wr_word == WAW'(w))) begin
                word_q[w] <= wr_data;
            end
        end

        assign mask[BLK*WORD_BITS +: WORD_BITS] = ENABLE ? word_q[w] : '0;
    end

    always_comb begin
        rd_data = '0;
        for (int w = 0; w < WORDS; w++) begin
            if (ENABLE && (rd_word == WAW'(w))) begin
                rd_data = word_q[w];
            end
        end
    end

endmodule

// File: rtl/rr_pick.sv
`timescale 1ns/1ps
module rr_pick #(
    parameter int SRC_W = 64,
    parameter int IDX_W = $clog2(SRC_W)
) (
    input  logic [SRC_W-1:0] pend,
    input  logic [IDX_W-1:0] start,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);
    logic [2*SRC_W-1:0] doubled;
    logic [SRC_W-1:0]   rotated;
    logic [IDX_W-1:0]   offset;

    always_comb begin
        doubled = {pend, pend};
        rotated = doubled[start +: SRC_W];
        hit     = 1'b0;
        offset  = '0;
        // lowest set bit of the rotated vector is the nearest source at or after start
        for (int i = SRC_W - 1; i >= 0; i--) begin
            if (rotated[i]) begin
                hit    = 1'b1;
                offset = IDX_W'(i);
            end
        end
        // SRC_W is a power of two, so the sum wraps by truncation
        idx = start + offset;
    end

endmodule

// File: rtl/rr_cpu_port.sv
`timescale 1ns/1ps
module rr_cpu_port #(
    parameter int SRC_W = 64,
    parameter int IDX_W = $clog2(SRC_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_W-1:0] pend,
    input  logic             take,
    output logic             grant_vld,
    output logic [IDX_W-1:0] grant_idx,
    output logic [IDX_W-1:0] ptr_o
);
    import rr_irq_pkg::*;

    port_state_e      state_q, state_d;
    logic [IDX_W-1:0] ptr_q;
    logic [IDX_W-1:0] idx_q;
    logic             hit;
    logic [IDX_W-1:0] pick_idx;

    rr_pick #(
        .SRC_W (SRC_W),
        .IDX_W (IDX_W)
    ) i_pick (
        .pend  (pend),
        .start (ptr_q),
        .hit   (hit),
        .idx   (pick_idx)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SCAN: if (hit)  state_d = ST_HOLD;
            ST_HOLD: if (take) state_d = ST_SCAN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_SCAN;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
            idx_q <= '0;
        end else begin
            if (state_q == ST_SCAN && hit) begin
                idx_q <= pick_idx;
            end
            if (state_q == ST_HOLD && take) begin
                ptr_q <= idx_q + 1'b1;
            end
        end
    end

    always_comb begin
        grant_vld = (state_q == ST_HOLD);
        grant_idx = idx_q;
        ptr_o     = ptr_q;
    end

endmodule

// File: rtl/rr_irq_selector.sv
`timescale 1ns/1ps
module rr_irq_selector #(
    parameter int SRC_W    = 64,
    parameter bit DUAL_CPU = 1'b1,
    localparam int WORDS   = SRC_W / 32,
    localparam int WAW     = (WORDS > 1) ? $clog2(WORDS) : 1,
    localparam int IDX_W   = $clog2(SRC_W),
    localparam int ADDR_W  = WAW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SRC_W-1:0]  src_status,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [31:0]       rd_data,
    input  logic [1:0]        take,
    output logic [1:0]        grant_vld,
    output logic [IDX_W-1:0]  grant_idx0,
    output logic [IDX_W-1:0]  grant_idx1,
    output logic [1:0]        cpu_irq
);
    import rr_irq_pkg::*;

    logic [SRC_W-1:0] mask_a  [NUM_CPU];
    logic [SRC_W-1:0] pend_a  [NUM_CPU];
    logic [31:0]      rdw_a   [NUM_CPU];
    logic [IDX_W-1:0] gidx_a  [NUM_CPU];
    logic [IDX_W-1:0] ptr_a   [NUM_CPU];

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        localparam bit EN = (c == 0) || DUAL_CPU;

        rr_mask_bank #(
            .SRC_W  (SRC_W),
            .WORDS  (WORDS),
            .WAW    (WAW),
            .ENABLE (EN)
        ) i_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_en && (wr_addr[WAW] == 1'(c))),
            .wr_word (wr_addr[WAW-1:0]),
            .wr_data (wr_data),
            .rd_word (rd_addr[WAW-1:0]),
            .rd_data (rdw_a[c]),
            .mask    (mask_a[c])
        );

        assign pend_a[c]  = src_status & mask_a[c];
        assign cpu_irq[c] = |pend_a[c];

        rr_cpu_port #(
            .SRC_W (SRC_W),
            .IDX_W (IDX_W)
        ) i_port (
            .clk       (clk),
            .rst_n     (rst_n),
            .pend      (pend_a[c]),
            .take      (take[c]),
            .grant_vld (grant_vld[c]),
            .grant_idx (gidx_a[c]),
            .ptr_o     (ptr_a[c])
        );
    end

    assign grant_idx0 = gidx_a[0];
    assign grant_idx1 = gidx_a[1];
    assign rd_data    = rd_addr[WAW] ? rdw_a[1] : rdw_a[0];

endmodule

// File: rtl/rr_irq_selector_chk.sv
`timescale 1ns/1ps
module rr_irq_selector_chk #(
    parameter int SRC_W    = 64,
    parameter bit DUAL_CPU = 1'b1,
    localparam int IDX_W   = $clog2(SRC_W)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       take,
    input logic [1:0]       grant_vld,
    input logic [IDX_W-1:0] grant_idx0,
    input logic [IDX_W-1:0] grant_idx1,
    input logic [1:0]       cpu_irq,
    input logic [SRC_W-1:0] pend0,
    input logic [SRC_W-1:0] pend1,
    input logic [IDX_W-1:0] ptr0,
    input logic [IDX_W-1:0] ptr1
);
    // R5
    grant_hold0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_vld[0] && !take[0] |=> grant_vld[0] && $stable(grant_idx0));
    // R5
    grant_hold1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_vld[1] && !take[1] |=> grant_vld[1] && $stable(grant_idx1));
    // R4
    ptr_step0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_vld[0] && take[0] |=> ptr0 == IDX_W'($past(grant_idx0) + 1'b1));
    // R4
    ptr_step1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_vld[1] && take[1] |=> ptr1 == IDX_W'($past(grant_idx1) + 1'b1));
    // R3
    pick_pending0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant_vld[0]) |-> (($past(pend0) >> grant_idx0) & SRC_W'(1)) != '0);
    // R3
    pick_pending1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant_vld[1]) |-> (($past(pend1) >> grant_idx1) & SRC_W'(1)) != '0);
    // R6
    idle_ptr0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !grant_vld[0] |=> ptr0 == $past(ptr0));
    // R6
    idle_ptr1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !grant_vld[1] |=> ptr1 == $past(ptr1));
    // R2
    irq_before_grant0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant_vld[0]) |-> $past(cpu_irq[0]));
    // R2
    irq_before_grant1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant_vld[1]) |-> $past(cpu_irq[1]));
    // R10
    single_cpu_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !DUAL_CPU |-> !grant_vld[1] && !cpu_irq[1]);

endmodule

bind rr_irq_selector rr_irq_selector_chk #(
    .SRC_W    (SRC_W),
    .DUAL_CPU (DUAL_CPU)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (take),
    .grant_vld  (grant_vld),
    .grant_idx0 (grant_idx0),
    .grant_idx1 (grant_idx1),
    .cpu_irq    (cpu_irq),
    .pend0      (pend_a[0]),
    .pend1      (pend_a[1]),
    .ptr0       (ptr_a[0]),
    .ptr1       (ptr_a[1])
);

// File: tb/test_rr_irq_selector.sv
`timescale 1ns/1ps
module test_rr_irq_selector;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] src = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [1:0]  take = '0;
    logic [1:0]  gv;
    logic [5:0]  gi0, gi1;
    logic [1:0]  irq;

    logic [31:0] s_src = '0;
    logic        s_wr_en = 1'b0;
    logic [1:0]  s_wr_addr = '0;
    logic [31:0] s_wr_data = '0;
    logic [1:0]  s_rd_addr = '0;
    logic [31:0] s_rd_data;
    logic [1:0]  s_gv;
    logic [4:0]  s_gi0, s_gi1;
    logic [1:0]  s_irq;

    always #4 clk = ~clk;

    rr_irq_selector #(.SRC_W(64), .DUAL_CPU(1'b1)) i_rr_irq_selector (
        .clk(clk), .rst_n(rst_n), .src_status(src),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .take(take),
        .grant_vld(gv), .grant_idx0(gi0), .grant_idx1(gi1), .cpu_irq(irq)
    );

    rr_irq_selector #(.SRC_W(32), .DUAL_CPU(1'b0)) i_rr_irq_selector_single (
        .clk(clk), .rst_n(rst_n), .src_status(s_src),
        .wr_en(s_wr_en), .wr_addr(s_wr_addr), .wr_data(s_wr_data),
        .rd_addr(s_rd_addr), .rd_data(s_rd_data), .take(2'b00),
        .grant_vld(s_gv), .grant_idx0(s_gi0), .grant_idx1(s_gi1), .cpu_irq(s_irq)
    );

    int          n_chk = 0;
    int          n_err = 0;
    bit          done = 1'b0;
    logic [63:0] mdl_mask [2];
    int          mdl_ptr  [2];
    logic [63:0] mdl_status;

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_pick(logic [63:0] p, int ptr, int w);
        for (int k = 0; k < w; k++) begin
            int j = (ptr + k) % w;
            if (p[j]) return j;
        end
        return -1;
    endfunction

    task automatic wr(int c, int word, logic [31:0] d);
        int blk;
        @(negedge clk);
        wr_en = 1'b1; wr_addr = {c[0], word[0]}; wr_data = d;
        @(posedge clk);
        #1 wr_en = 1'b0;
        blk = word ^ 1;
        mdl_mask[c][blk*32 +: 32] = d;
    endtask

    task automatic rd_chk(int c, int word, logic [31:0] exp, string req);
        @(negedge clk);
        rd_addr = {c[0], word[0]};
        #1 check(rd_data == exp, req, "mask readback", rd_data, exp);
    endtask

    task automatic set_src(logic [63:0] v);
        @(negedge clk);
        src = v;
        mdl_status = v;
    endtask

    task automatic serve(int c, string req);
        int e, a;
        e = exp_pick(mdl_status & mdl_mask[c], mdl_ptr[c], 64);
        repeat (2) @(posedge clk);
        @(negedge clk);
        a = gv[c] ? ((c == 0) ? int'(gi0) : int'(gi1)) : -1;
        if (e < 0) begin
            check(gv[c] == 1'b0, req, "unexpected grant", a, e);
        end else begin
            check(a == e, req, "grant index", a, e);
            take[c] = 1'b1;
            @(posedge clk);
            @(negedge clk);
            take[c] = 1'b0;
            mdl_ptr[c] = (e + 1) % 64;
        end
    endtask

    // drop all sources; held offers keep the old index (R5), then nothing is offered (R6)
    task automatic close_all();
        @(negedge clk);
        src = '0;
        serve(0, "R5"); serve(1, "R5");
        mdl_status = '0;
        serve(0, "R6"); serve(1, "R6");
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        n_chk++; n_err++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        void'($urandom(32'd20250308));
        mdl_mask[0] = '0; mdl_mask[1] = '0;
        mdl_ptr[0] = 0;   mdl_ptr[1] = 0;
        mdl_status = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        #1 check(gv == 2'b00, "R1", "grant after reset", gv, 0);
        check(irq == 2'b00, "R1", "irq after reset", irq, 0);
        rd_chk(0, 0, 32'h0, "R1"); rd_chk(0, 1, 32'h0, "R1");
        rd_chk(1, 0, 32'h0, "R1"); rd_chk(1, 1, 32'h0, "R1");

        // R10 single-processor variant
        @(negedge clk);
        s_wr_en = 1'b1; s_wr_addr = 2'b10; s_wr_data = 32'hFFFF_FFFF;
        @(negedge clk);
        s_wr_addr = 2'b00; s_wr_data = 32'h8000_0000;
        @(negedge clk);
        s_wr_en = 1'b0; s_src = 32'hFFFF_FFFF; s_rd_addr = 2'b10;
        repeat (2) @(negedge clk);
        check(s_rd_data == 32'h0, "R10", "disabled mask readback", s_rd_data, 0);
        check(s_gv[1] == 1'b0 && s_irq[1] == 1'b0, "R10", "disabled cpu quiet", {s_gv[1], s_irq[1]}, 0);
        check(s_gv[0] == 1'b1 && s_gi0 == 5'd31, "R10", "cpu0 of 32-wide grant", s_gi0, 31);

        // R1 pointer zero, R4 stepping, R9 latency
        wr(0, 0, 32'hFFFF_FFFF); wr(0, 1, 32'hFFFF_FFFF);
        @(negedge clk);
        src = '1; mdl_status = '1;
        #1 check(irq[0] == 1'b1, "R2", "irq same cycle", irq[0], 1);
        @(negedge clk);
        check(gv[0] == 1'b1 && gi0 == 6'd0, "R9", "grant one edge later", gi0, 0);
        check(gi0 == 6'd0, "R1", "first grant from pointer zero", gi0, 0);
        take[0] = 1'b1;
        @(negedge clk);
        take[0] = 1'b0; mdl_ptr[0] = 1;
        check(gv[0] == 1'b0, "R9", "valid low one cycle after take", gv[0], 0);
        @(negedge clk);
        check(gv[0] == 1'b1 && gi0 == 6'd1, "R4", "next grant after take", gi0, 1);
        serve(0, "R4"); serve(0, "R4");
        close_all();

        // R7 word reversal: word 0 covers sources 32..63
        wr(0, 0, 32'h0000_0001); wr(0, 1, 32'h0);
        rd_chk(0, 0, 32'h0000_0001, "R7"); rd_chk(0, 1, 32'h0, "R7");
        set_src(64'h0000_0001_0000_0001);
        serve(0, "R7");
        check(irq[1] == 1'b0, "R8", "unrouted cpu quiet", irq[1], 0);
        close_all();

        // R6 no pending: take pulses ignored, pointer held
        set_src(64'h0000_0000_FFFF_FFFE);
        @(negedge clk);
        check(irq[0] == 1'b0 && gv[0] == 1'b0, "R6", "disjoint mask no grant", {irq[0], gv[0]}, 0);
        take = 2'b11;
        @(negedge clk);
        take = 2'b00;
        close_all();

        // R3 wrap at top of range, R8 overlap routing
        wr(0, 0, 32'hFFFF_FFFF); wr(0, 1, 32'hFFFF_FFFF);
        set_src(64'h4000_0000_0000_0000);
        serve(0, "R3");
        close_all();
        set_src(64'h8000_0000_0000_0001);
        serve(0, "R3"); serve(0, "R3");
        close_all();
        wr(1, 1, 32'h0000_0F21); wr(0, 1, 32'h0000_00F1); wr(0, 0, 32'h0);
        set_src(64'h0000_0000_0000_0FFF);
        for (int k = 0; k < 5; k++) begin
            serve(0, "R8"); serve(1, "R8");
        end
        close_all();

        // random mix
        for (int it = 0; it < 40; it++) begin
            for (int c = 0; c < 2; c++) begin
                for (int w = 0; w < 2; w++) begin
                    wr(c, w, ($urandom % 4 == 0) ? 32'h0 : ($urandom & $urandom));
                end
            end
            set_src({$urandom, $urandom} | {$urandom, $urandom});
            for (int k = 0; k < 1 + int'($urandom % 5); k++) begin
                serve(0, "R3"); serve(1, "R8");
            end
            close_all();
        end

        finish_run();
    end

endmodule